// File: doc/BRIEF.md
# Reference Clock Protection Switch Controller

This controller chooses which of three timing references feeds a downstream phase-locked loop: a primary (A), a secondary (B) and a backup (BU). It watches a loss-of-clock flag per reference and a two-bit desired-reference request. Mode inputs select autonomous or manual operation, revertive return, output squelching, switch lockout, a forced-switch override and a lockout clear. After every switch a programmable lock timer runs so the loop can settle. While it runs, the switch-in-progress interrupt is held high.

In autonomous mode the controller leaves a failed reference without being asked. It tries A and B before BU. It can return to the requested reference once the lock timer has run out. In manual mode it only follows requests. Each request waits for the lock timer and for the requested reference to be healthy. A saturating switch counter can freeze the selection after a set number of transitions. The counter stays frozen until an external clear pulse.

Top module: `refclk_guard`

## Requirements
- R1: While reset is held, the selection code is 00 (A), and the switch-in-progress, lockout and squelch outputs are low.
- R2: On the first clock edge after reset, if A shows no loss of clock, the lock timer starts. The switch-in-progress output is then high for exactly TIMEOUT cycles. Any switch also restarts the lock timer.
- R3: In autonomous mode, once the selected reference is lost, the next edge moves the selection to a healthy reference, ignoring the lock timer. The candidates are tried in the order A, B, BU, skipping the current one. So losing B picks A if A is healthy, and BU only when A is also lost.
- R4: In autonomous mode, after a fallback switch with revert enabled, the selection returns to the requested reference. The return happens on the first edge after the lock timer has expired, if that reference is healthy. With revert disabled, the selection stays on the fallback reference until the request changes.
- R5: With lockout enabled, no switch happens once three switches have been counted. The next attempted switch raises the lockout output and leaves the selection unchanged.
- R6: Driving the active-low lockout-clear input low for one edge clears the switch count and drops the lockout output. Switching resumes on the following edge.
- R7: The squelch output is high when squelch is enabled and the selected reference shows loss of clock. It is also high when squelch is enabled while the force override is asserted. It is low in all other cases.
- R8: Manual start-up with A lost works as follows. If the requested reference is healthy, it is selected on the first edge and the lock timer starts. If it is lost and squelch is enabled, it is selected without a timer. Otherwise the selection stays on A.
- R9: In manual mode a requested change is taken only when the lock timer has expired and the requested reference is healthy. A lost selected reference never causes a switch.
- R10: The inconsistency output is high whenever the selection differs from the decoded request, or the lockout output is high. This covers early requests, unhealthy requested references and lockout.
- R11: While the force override is asserted, a request that differs from the selection is taken on the next edge. This ignores loss-of-clock flags and the lock timer.
- R12: Selection codes are 00 = A, 01 = B and 10 = BU. A request of 11 is decoded as A, and the selection code never reads 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| want_hi | input | 1 | Requested reference code, upper bit |
| want_lo | input | 1 | Requested reference code, lower bit |
| los_a | input | 1 | Loss of clock on A (1 = lost) |
| los_b | input | 1 | Loss of clock on B (1 = lost) |
| los_bu | input | 1 | Loss of clock on BU (1 = lost) |
| auto_mode | input | 1 | 1 = autonomous, 0 = manual |
| revert_en | input | 1 | Return to the requested reference after a fallback |
| squelch_en | input | 1 | Allow forcing the output clock and sync low |
| lockout_en | input | 1 | Enable switch-count lockout |
| force_sw | input | 1 | Override: switch without health or timer checks |
| lock_clr_n | input | 1 | Active-low clear of the switch counter |
| sel_code | output | 2 | Current reference selection |
| squelch | output | 1 | Force output clock and sync low |
| irq_switching | output | 1 | Switch in progress (lock timer running) |
| irq_inconsistent | output | 1 | Selection differs from request, or locked out |
| irq_lockout | output | 1 | Switch attempted after the limit was reached |

## Verification
The bench builds the controller with TIMEOUT = 4 and the default limit of three switches. This lets it count the whole lock window edge by edge and reach lockout within a few dozen cycles. It drives every fallback path, a revert at the exact expiry edge, a lockout and clear cycle, the three manual start-up outcomes, and a sweep over all four request codes.

// File: rtl/refclk_guard_pkg.sv
package refclk_guard_pkg;

    typedef enum logic [1:0] {
        REF_A  = 2'b00,
        REF_B  = 2'b01,
        REF_BU = 2'b10
    } ref_e;

    // Request decode; the unused code falls back to the primary.
    function automatic ref_e decode_want(input logic hi, input logic lo);
        case ({hi, lo})
            2'b01:   return REF_B;
            2'b10:   return REF_BU;
            default: return REF_A;
        endcase
    endfunction

    typedef struct packed {
        ref_e sel;
        logic started;
        logic hold;
        ref_e want_prev;
    } guard_st_t;

endpackage

// File: rtl/refclk_lock_timer.sv
module refclk_lock_timer #(
    parameter int unsigned TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int unsigned CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] START = CW'(TIMEOUT);

    typedef struct packed {
        logic [CW-1:0] left;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (load) begin
            tm_d.left = START;
        end else if (tm_q.left != '0) begin
            tm_d.left = tm_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign busy = (tm_q.left != '0);

    // R2
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

endmodule

// File: rtl/refclk_switch_counter.sv
module refclk_switch_counter #(
    parameter int unsigned LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic bump,
    input  logic deny,
    output logic at_limit,
    output logic over
);
    localparam int unsigned W = $clog2(LIMIT + 2);
    localparam logic [W-1:0] TOP  = W'(LIMIT);
    localparam logic [W-1:0] PAST = W'(LIMIT + 1);

    typedef struct packed {
        logic [W-1:0] n;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!clr_n) begin
            c_d.n = '0;
        end else if (deny) begin
            c_d.n = PAST;
        end else if (bump && (c_q.n < TOP)) begin
            c_d.n = c_q.n + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign at_limit = (c_q.n >= TOP);
    assign over     = (c_q.n > TOP);

    // R5
    deny_sets_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deny && clr_n) |=> over);

    // R6
    clear_drops_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !over);

endmodule

// File: rtl/refclk_fallback_pick.sv
module refclk_fallback_pick
    import refclk_guard_pkg::*;
(
    input  ref_e       cur_ref,
    input  logic [2:0] present,
    output logic       found,
    output ref_e       pick
);
    // Index order doubles as priority: A, then B, then BU.
    always_comb begin
        found = 1'b0;
        pick  = REF_A;
        for (int i = 0; i < 3; i++) begin
            if (!found && (2'(i) != cur_ref) && present[i]) begin
                found = 1'b1;
                pick  = ref_e'(2'(i));
            end
        end
    end

endmodule

// File: rtl/refclk_guard.sv
module refclk_guard
    import refclk_guard_pkg::*;
#(
    parameter int unsigned TIMEOUT      = 1000,
    parameter int unsigned SWITCH_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want_hi,
    input  logic       want_lo,
    input  logic       los_a,
    input  logic       los_b,
    input  logic       los_bu,
    input  logic       auto_mode,
    input  logic       revert_en,
    input  logic       squelch_en,
    input  logic       lockout_en,
    input  logic       force_sw,
    input  logic       lock_clr_n,
    output logic [1:0] sel_code,
    output logic       squelch,
    output logic       irq_switching,
    output logic       irq_inconsistent,
    output logic       irq_lockout
);
    guard_st_t st_d, st_q;

    ref_e       want;
    logic [2:0] present;
    logic       busy, at_limit, over, lock_block;
    logic       fb_found;
    ref_e       fb_pick;
    logic       cand_ok, cand_fb, sq_pick, arm, bump, deny;
    ref_e       cand;

    assign want       = decode_want(want_hi, want_lo);
    assign present    = ~{los_bu, los_b, los_a};
    assign lock_block = lockout_en && at_limit;

    refclk_fallback_pick u_pick (
        .cur_ref (st_q.sel),
        .present (present),
        .found   (fb_found),
        .pick    (fb_pick)
    );

    refclk_lock_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (arm),
        .busy  (busy)
    );

    refclk_switch_counter #(.LIMIT(SWITCH_LIMIT)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (lock_clr_n),
        .bump     (bump),
        .deny     (deny),
        .at_limit (at_limit),
        .over     (over)
    );

    always_comb begin
        st_d    = st_q;
        cand_ok = 1'b0;
        cand    = st_q.sel;
        cand_fb = 1'b0;
        sq_pick = 1'b0;
        arm     = 1'b0;
        bump    = 1'b0;
        deny    = 1'b0;

        if (!st_q.started) begin
            st_d.started = 1'b1;
            if (present[REF_A]) begin
                arm = 1'b1;
            end else if (present[want]) begin
                cand_ok = 1'b1;
                cand    = want;
            end else if (auto_mode) begin
                cand_ok = fb_found;
                cand    = fb_pick;
                cand_fb = 1'b1;
            end else if (squelch_en) begin
                sq_pick = 1'b1;
            end
        end else if (force_sw) begin
            if (want != st_q.sel) begin
                cand_ok = 1'b1;
                cand    = want;
            end
        end else if (auto_mode) begin
            if (!present[st_q.sel]) begin
                cand_ok = fb_found;
                cand    = fb_pick;
                cand_fb = 1'b1;
            end else if ((want != st_q.sel) && !busy && present[want]
                         && (!st_q.hold || revert_en)) begin
                cand_ok = 1'b1;
                cand    = want;
            end
        end else begin
            if ((want != st_q.sel) && !busy && present[want]) begin
                cand_ok = 1'b1;
                cand    = want;
            end
        end

        if (want != st_q.want_prev) st_d.hold = 1'b0;
        st_d.want_prev = want;

        if (cand_ok) begin
            if (lock_block) begin
                deny = 1'b1;
            end else begin
                st_d.sel  = cand;
                st_d.hold = cand_fb;
                bump      = 1'b1;
                arm       = 1'b1;
            end
        end

        if (sq_pick) st_d.sel = want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel: REF_A, started: 1'b0, hold: 1'b0, want_prev: REF_A};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_code         = st_q.sel;
    assign irq_switching    = busy;
    assign irq_lockout      = over;
    assign irq_inconsistent = (st_q.sel != want) || over;
    assign squelch          = squelch_en && (!present[st_q.sel] || force_sw);

    // R12
    sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_code != 2'b11);

    // R5
    lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout_en && at_limit) |=> $stable(st_q.sel));

    // R9
    manual_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && !auto_mode && !force_sw && busy) |=> $stable(st_q.sel));

    // R2
    switch_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_d.sel != st_q.sel) && !sq_pick) |=> irq_switching);

    // R3
    auto_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && auto_mode && !force_sw && !present[st_q.sel]
         && fb_found && !lock_block) |=> (st_q.sel != $past(st_q.sel)));

endmodule

// File: tb/refclk_guard_bench.sv
module refclk_guard_bench;
    localparam int unsigned TO = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic want_hi = 1'b0, want_lo = 1'b0;
    logic los_a = 1'b0, los_b = 1'b0, los_bu = 1'b0;
    logic auto_mode = 1'b1, revert_en = 1'b0, squelch_en = 1'b0;
    logic lockout_en = 1'b1, force_sw = 1'b0, lock_clr_n = 1'b1;
    logic [1:0] sel_code;
    logic squelch, irq_switching, irq_inconsistent, irq_lockout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    refclk_guard #(.TIMEOUT(TO), .SWITCH_LIMIT(3)) u_refclk_guard (
        .clk(clk), .rst_n(rst_n), .want_hi(want_hi), .want_lo(want_lo),
        .los_a(los_a), .los_b(los_b), .los_bu(los_bu),
        .auto_mode(auto_mode), .revert_en(revert_en), .squelch_en(squelch_en),
        .lockout_en(lockout_en), .force_sw(force_sw), .lock_clr_n(lock_clr_n),
        .sel_code(sel_code), .squelch(squelch), .irq_switching(irq_switching),
        .irq_inconsistent(irq_inconsistent), .irq_lockout(irq_lockout)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_want(input int w);
        want_hi = w[1];
        want_lo = w[0];
    endtask

    task automatic restart;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin
        // ---------------- autonomous scenario ----------------
        set_want(0);
        step(2);
        chk("R1 sel", sel_code, 0);
        chk("R1 switching", irq_switching, 0);
        chk("R1 lockout", irq_lockout, 0);
        chk("R1 squelch", squelch, 0);
        rst_n = 1'b1;
        step(1);
        chk("R2 busy first", irq_switching, 1);
        step(3);
        chk("R2 busy last", irq_switching, 1);
        step(1);
        chk("R2 expired", irq_switching, 0);

        los_a = 1'b1;
        step(1);
        chk("R3 A lost picks B", sel_code, 1);
        chk("R2 switch arms timer", irq_switching, 1);
        los_b = 1'b1;
        step(1);
        chk("R3 A,B lost picks BU", sel_code, 2);
        revert_en = 1'b1;
        los_a = 1'b0;
        los_b = 1'b0;
        step(4);
        chk("R4 no early revert", sel_code, 2);
        step(1);
        chk("R4 revert at expiry", sel_code, 0);
        chk("R10 consistent", irq_inconsistent, 0);

        los_a = 1'b1;
        step(1);
        chk("R5 blocked sel", sel_code, 0);
        chk("R5 lockout irq", irq_lockout, 1);
        chk("R10 lockout inconsistent", irq_inconsistent, 1);
        chk("R7 squelch disabled", squelch, 0);
        squelch_en = 1'b1;
        #1;
        chk("R7 squelch lost sel", squelch, 1);
        squelch_en = 1'b0;
        lock_clr_n = 1'b0;
        step(1);
        chk("R6 cleared", irq_lockout, 0);
        chk("R6 sel held", sel_code, 0);
        lock_clr_n = 1'b1;
        step(1);
        chk("R6 resumes", sel_code, 1);

        revert_en = 1'b0;
        los_a = 1'b0;
        step(8);
        chk("R4 no revert", sel_code, 1);
        chk("R10 want differs", irq_inconsistent, 1);
        los_b = 1'b1;
        step(1);
        chk("R3 B lost picks A over BU", sel_code, 0);
        los_b = 1'b0;

        // ---------------- manual start-up ----------------
        auto_mode = 1'b0;
        los_a = 1'b1;
        set_want(1);
        restart();
        chk("R8 desired healthy", sel_code, 1);
        chk("R8 timer", irq_switching, 1);

        los_b = 1'b1;
        squelch_en = 1'b1;
        restart();
        chk("R8 squelch pick", sel_code, 1);
        chk("R7 squelched", squelch, 1);
        chk("R8 no timer", irq_switching, 0);

        squelch_en = 1'b0;
        restart();
        chk("R8 stays A", sel_code, 0);
        chk("R7 no squelch", squelch, 0);
        chk("R10 absent desired", irq_inconsistent, 1);

        // ---------------- manual requests ----------------
        los_a = 1'b0;
        los_b = 1'b0;
        set_want(0);
        restart();
        set_want(1);
        #1;
        chk("R10 early request", irq_inconsistent, 1);
        step(4);
        chk("R9 waits timer", sel_code, 0);
        step(1);
        chk("R9 switches", sel_code, 1);

        set_want(2);
        los_bu = 1'b1;
        step(10);
        chk("R9 unhealthy request", sel_code, 1);
        chk("R10 unhealthy request", irq_inconsistent, 1);

        los_b = 1'b1;
        step(3);
        chk("R9 no switch on loss", sel_code, 1);
        chk("R7 loss no enable", squelch, 0);
        squelch_en = 1'b1;
        #1;
        chk("R7 loss enabled", squelch, 1);
        squelch_en = 1'b0;

        force_sw = 1'b1;
        step(1);
        chk("R11 forced to lost ref", sel_code, 2);
        chk("R11 timer", irq_switching, 1);
        los_bu = 1'b0;
        los_b = 1'b0;
        squelch_en = 1'b1;
        #1;
        chk("R11 hand squelch", squelch, 1);
        squelch_en = 1'b0;
        #1;
        chk("R11 hand release", squelch, 0);
        force_sw = 1'b0;

        // ---------------- request code sweep ----------------
        lockout_en = 1'b0;
        for (int w = 0; w < 4; w++) begin
            set_want(w);
            step(TO + 2);
            chk("R12 code", sel_code, (w == 3) ? 0 : w);
            chk("R12 consistent", irq_inconsistent, 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule